// File: doc/BRIEF.md
# Wake Event Latch Unit

This block records wake-up events from a bank of up to 32 sources (external pins or internal interrupt lines) so that a sleeping system can find out afterwards what woke it. Each source passes through a two-flop synchronizer and an edge detector. A per-source polarity bit selects whether a rising or a falling transition counts. Every detected edge sets a sticky bit in a raw event register, and that happens whether or not the source is enabled for wake-up.

A per-source enable bit gates the raw events into a masked view. The OR of the masked view drives a registered wake request toward power control. Software reaches four registers through a small synchronous bus. A raw event bit is cleared by writing a one to it. A bit stays set after its source returns to idle, and it stays set after the matching interrupt has been serviced elsewhere.

Top module: `wk_event_latch`

## Requirements
- R1: After reset the enable register reads 0, the polarity register reads the parameter POL_RESET, the raw and masked event registers read 0, and wake_o is 0.
- R2: A source whose polarity bit is 1 sets its raw event bit on a 0-to-1 transition of its synchronized input and not on a 1-to-0 transition.
- R3: A source whose polarity bit is 0 sets its raw event bit on a 1-to-0 transition of its synchronized input and not on a 0-to-1 transition.
- R4: Raw event bits latch whether or not the source's enable bit (register address 0) is set.
- R5: A write to address 2 clears every raw event bit whose write-data bit is 1 and leaves the bits whose write-data bit is 0 unchanged.
- R6: When an edge is detected on a source in the same cycle as a clearing write to that source's bit, the raw event bit ends up set.
- R7: Address 3 reads the raw event register ANDed with the enable register.
- R8: wake_o is 1 in the cycle after any bit of (raw AND enable) is 1, and 0 in the cycle after all of them are 0.
- R9: A raw event bit stays set while no clearing write to that bit occurs, whatever its input does after the edge.
- R10: Address 3 is read-only: a write to it changes no register.
- R11: Register map: 0 enable, 1 polarity, 2 raw events, 3 masked events. A read strobe at a clock edge yields bus_rvalid and bus_rdata at the next edge, and bus_rvalid is 0 in any cycle that follows no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | NSRC | Asynchronous wake source levels |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | NSRC | Write data |
| bus_rdata | output | NSRC | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| wake_o | output | 1 | Registered wake request |

## Verification
The assertions assume the source lines are quiet during reset. They also assume read and write strobes are never given in the same cycle. Under those conditions, every newly set raw event bit can be traced to a detected edge in the previous cycle, and every bit that is lost can be traced to a clearing write. The stimulus holds all sources low through reset. It issues each bus access on its own, on the falling clock edge. It times the same-cycle clear so that the write lands exactly in the cycle where the synchronized edge is visible.

// File: rtl/wk_pkg.sv
package wk_pkg;
  // Register selector; the encoding is the bus address
  typedef enum logic [1:0] {
    REG_ENABLE   = 2'd0,
    REG_POLARITY = 2'd1,
    REG_RAW      = 2'd2,
    REG_MASKED   = 2'd3
  } wk_reg_e;

  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/wk_sync.sv
module wk_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  localparam int unsigned STAGES = wk_pkg::SYNC_STAGES;

  genvar b;
  generate
    for (b = 0; b < W; b++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], async_in[b]};
      end
      assign sync_out[b] = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/wk_edge_latch.sv
module wk_edge_latch #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] clr,
  output logic [W-1:0] edge_vec,
  output logic [W-1:0] raw
);
  logic [W-1:0] lvl_d;

  always_ff @(posedge clk) begin
    if (rst) lvl_d <= '0;
    else     lvl_d <= lvl;
  end

  genvar b;
  generate
    for (b = 0; b < W; b++) begin : g_src
      logic rise, fall;
      assign rise        = lvl[b] & ~lvl_d[b];
      assign fall        = ~lvl[b] & lvl_d[b];
      assign edge_vec[b] = pol[b] ? rise : fall;

      // New edge wins over a simultaneous clear
      always_ff @(posedge clk) begin
        if (rst) raw[b] <= 1'b0;
        else     raw[b] <= (raw[b] & ~clr[b]) | edge_vec[b];
      end
    end
  endgenerate
endmodule

// File: rtl/wk_regs.sv
module wk_regs #(
  parameter int unsigned W         = 32,
  parameter logic [W-1:0] POL_RESET = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         bus_wr,
  input  logic         bus_rd,
  input  logic [1:0]   bus_addr,
  input  logic [W-1:0] bus_wdata,
  input  logic [W-1:0] raw,
  output logic [W-1:0] en,
  output logic [W-1:0] pol,
  output logic [W-1:0] clr,
  output logic [W-1:0] rdata,
  output logic         rvalid,
  output logic         wake
);
  import wk_pkg::*;

  wk_reg_e      sel;
  logic [W-1:0] masked;
  logic [W-1:0] rd_mux;

  assign sel    = wk_reg_e'(bus_addr);
  assign masked = raw & en;
  assign clr    = (bus_wr && sel == REG_RAW) ? bus_wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      en  <= '0;
      pol <= POL_RESET;
    end else if (bus_wr) begin
      if (sel == REG_ENABLE)   en  <= bus_wdata;
      if (sel == REG_POLARITY) pol <= bus_wdata;
    end
  end

  always_comb begin
    case (sel)
      REG_ENABLE:   rd_mux = en;
      REG_POLARITY: rd_mux = pol;
      REG_RAW:      rd_mux = raw;
      default:      rd_mux = masked;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
      wake   <= 1'b0;
    end else begin
      rvalid <= bus_rd;
      if (bus_rd) rdata <= rd_mux;
      wake   <= |masked;
    end
  end
endmodule

// File: rtl/wk_event_latch.sv
module wk_event_latch #(
  parameter int unsigned     NSRC      = 32,
  parameter logic [NSRC-1:0] POL_RESET = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_in,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [1:0]      bus_addr,
  input  logic [NSRC-1:0] bus_wdata,
  output logic [NSRC-1:0] bus_rdata,
  output logic            bus_rvalid,
  output logic            wake_o
);
  logic [NSRC-1:0] lvl_vec;
  logic [NSRC-1:0] edge_vec;
  logic [NSRC-1:0] raw_vec;
  logic [NSRC-1:0] en_vec;
  logic [NSRC-1:0] pol_vec;
  logic [NSRC-1:0] clr_vec;

  wk_sync #(.W(NSRC)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (src_in),
    .sync_out (lvl_vec)
  );

  wk_edge_latch #(.W(NSRC)) u_latch (
    .clk      (clk),
    .rst      (rst),
    .lvl      (lvl_vec),
    .pol      (pol_vec),
    .clr      (clr_vec),
    .edge_vec (edge_vec),
    .raw      (raw_vec)
  );

  wk_regs #(.W(NSRC), .POL_RESET(POL_RESET)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .raw       (raw_vec),
    .en        (en_vec),
    .pol       (pol_vec),
    .clr       (clr_vec),
    .rdata     (bus_rdata),
    .rvalid    (bus_rvalid),
    .wake      (wake_o)
  );
endmodule

// File: rtl/wk_event_latch_chk.sv
module wk_event_latch_chk #(
  parameter int unsigned W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         bus_wr,
  input logic         bus_rd,
  input logic [1:0]   bus_addr,
  input logic         bus_rvalid,
  input logic         wake_o,
  input logic [W-1:0] raw_q,
  input logic [W-1:0] en_q,
  input logic [W-1:0] edge_vec
);
  logic clr_hit;
  assign clr_hit = bus_wr && (bus_addr == 2'd2);

  AST_RVALID_AFTER_RD: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid); // R11

  AST_NO_RVALID_IDLE: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> !bus_rvalid); // R11

  AST_WAKE_SET: assert property (@(posedge clk) disable iff (rst)
    (|(raw_q & en_q)) |=> wake_o); // R8

  AST_WAKE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    !(|(raw_q & en_q)) |=> !wake_o); // R8

  AST_RAW_STICKY: assert property (@(posedge clk) disable iff (rst)
    !clr_hit |=> ((raw_q & $past(raw_q)) == $past(raw_q))); // R9

  AST_RAW_NEEDS_EDGE: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((raw_q & ~$past(raw_q) & ~$past(edge_vec)) == '0)); // R2

  AST_EDGE_BEATS_CLR: assert property (@(posedge clk) disable iff (rst)
    (|edge_vec) |=> ((raw_q & $past(edge_vec)) == $past(edge_vec))); // R6
endmodule

bind wk_event_latch wk_event_latch_chk #(.W(NSRC)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .bus_addr   (bus_addr),
  .bus_rvalid (bus_rvalid),
  .wake_o     (wake_o),
  .raw_q      (raw_vec),
  .en_q       (en_vec),
  .edge_vec   (edge_vec)
);

// File: tb/tb_wk_event_latch.sv
module tb_wk_event_latch;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 32;
  localparam logic [NSRC-1:0] POL_INIT = 32'hA500_0000;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NSRC-1:0] src_in = '0;
  logic            bus_wr = 1'b0;
  logic            bus_rd = 1'b0;
  logic [1:0]      bus_addr = '0;
  logic [NSRC-1:0] bus_wdata = '0;
  logic [NSRC-1:0] bus_rdata;
  logic            bus_rvalid;
  logic            wake_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  logic [NSRC-1:0] exp_q[$];
  string           tag_q[$];

  wk_event_latch #(.NSRC(NSRC), .POL_RESET(POL_INIT)) dut (
    .clk, .rst, .src_in, .bus_wr, .bus_rd, .bus_addr, .bus_wdata,
    .bus_rdata, .bus_rvalid, .wake_o
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(bit ok, string tag, logic [NSRC-1:0] act, logic [NSRC-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pop expected reads as the design returns them
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R11 unexpected rvalid", bus_rdata, '0);
      end else begin
        automatic logic [NSRC-1:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(bus_rdata === e, t, bus_rdata, e);
      end
    end
  end

  task automatic wr(logic [1:0] a, logic [NSRC-1:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, logic [NSRC-1:0] e, string t);
    bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    bus_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk_wake(logic e, string t);
    check(wake_o === e, t, {31'd0, wake_o}, {31'd0, e});
  endtask

  initial begin
    idle(3);
    rst = 1'b0;
    idle(2);
    // R1 reset state
    rd(2'd0, '0, "R1 enable reset");
    rd(2'd1, POL_INIT, "R1 polarity reset");
    rd(2'd2, '0, "R1 raw reset");
    rd(2'd3, '0, "R1 masked reset");
    chk_wake(1'b0, "R1 wake reset");

    // R2/R4: bits 0..7 rising, 8..15 falling; enables all 0
    wr(2'd1, 32'h0000_00FF);
    src_in = 32'h0000_FFFF;
    idle(5);
    rd(2'd2, 32'h0000_00FF, "R2 rising latched, R4 without enable");
    chk_wake(1'b0, "R8 no wake while disabled");

    // R3: falling edges on 8..15; rising bits stay (R9)
    src_in = '0;
    idle(5);
    rd(2'd2, 32'h0000_FFFF, "R3 falling latched");
    rd(2'd2, 32'h0000_FFFF, "R9 bits 0..7 sticky after input idle");

    // R7/R8 masked view and wake
    wr(2'd0, 32'h0000_0F0F);
    idle(2);
    rd(2'd3, 32'h0000_0F0F, "R7 masked view");
    chk_wake(1'b1, "R8 wake on enabled event");

    // R10 masked register read-only
    wr(2'd3, '0);
    rd(2'd3, 32'h0000_0F0F, "R10 masked unchanged after write");
    rd(2'd2, 32'h0000_FFFF, "R10 raw unchanged after write");
    rd(2'd0, 32'h0000_0F0F, "R10 enable unchanged after write");

    // R5 write-one-to-clear
    wr(2'd2, 32'h0000_0F00);
    rd(2'd2, 32'h0000_F0FF, "R5 partial clear");
    wr(2'd2, '0);
    rd(2'd2, 32'h0000_F0FF, "R5 zero write keeps bits");
    rd(2'd3, 32'h0000_000F, "R7 masked after clear");
    chk_wake(1'b1, "R8 wake still pending");
    wr(2'd2, 32'h0000_000F);
    idle(2);
    chk_wake(1'b0, "R8 wake drops after clear");
    rd(2'd3, '0, "R7 masked empty");

    // R6 edge in same cycle as clear of that bit
    wr(2'd2, '1);
    wr(2'd1, 32'h0001_00FF);
    src_in[16] = 1'b1;
    idle(5);
    src_in[16] = 1'b0;
    idle(5);
    rd(2'd2, 32'h0001_0000, "R2 bit16 rising only");
    src_in[16] = 1'b1;
    idle(2);
    wr(2'd2, 32'h0001_0000);
    idle(3);
    rd(2'd2, 32'h0001_0000, "R6 edge beats clear");
    wr(2'd2, 32'h0001_0000);
    rd(2'd2, '0, "R5 clear without edge");

    idle(4);
    check(exp_q.size() == 0, "R11 every read answered", exp_q.size(), 0);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL R11 watchdog: actual=hang expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule